// File: doc/BRIEF.md
# Shared PCI Interrupt Steering Router

This block gathers the four shared interrupt pins (INTA to INTD) of a set of PCI device slots and steers them onto a 16-line input vector of a legacy interrupt controller. Each pin of each slot is first rotated onto one of four intermediate interrupt lines (PIRQ A to D). The rotation depends on the slot number, so that devices using only INTA still spread across all four lines. Each intermediate line is the OR of every device pin rotated onto it.

Four byte-wide steering registers choose which legacy IRQ each intermediate line drives. A steering value of 16 or more disconnects that line. Two or more lines may point at the same IRQ, and their levels are then ORed. Two byte-wide trigger-mode registers hold one bit per legacy IRQ, with 1 meaning level-triggered. They are plain storage and are brought out as a 16-bit vector for the interrupt controller. Pin levels and register contents are captured on the clock edge, and the IRQ outputs are a combinational function of that captured state. Every change therefore shows on the outputs exactly one clock later.

Top module: `intx_steer_router`

## Requirements
- R1: While `rst` is high at a clock edge, all captured pin levels clear, all four steering bytes become 0x80 (disconnected) and both trigger-mode bytes become 0x00. After reset, `irq_out` stays 0 whatever `level_in` does, until a steering byte is written.
- R2: Input bit `level_in[4*s+p]` is pin p of slot s, with p = 0..3 for INTA..INTD. It feeds intermediate line (p + s - 1) mod 4, where lines 0..3 are PIRQ A..D.
- R3: An intermediate line is high when at least one device pin rotated onto it is high.
- R4: A write with `cfg_sel` 0, 1, 2 or 3 loads the steering byte of PIRQ A, B, C or D. A steering value v in 0..15 drives that line's level onto `irq_out[v]`.
- R5: A steering value of 16 to 255 connects that intermediate line to no IRQ output.
- R6: An IRQ output is the OR of every intermediate line whose steering byte equals its number. At most four IRQ outputs are high at once.
- R7: A write with `cfg_sel` 4 loads `trig_mode[7:0]` (IRQ 0..7), and `cfg_sel` 5 loads `trig_mode[15:8]` (IRQ 8..15). Bit n of `trig_mode` belongs to IRQ n. These bytes have no effect on `irq_out`.
- R8: Writes with `cfg_sel` 6 or 7 change no register: `trig_mode` and `irq_out` are unaffected.
- R9: `irq_out` reflects `level_in` and the register contents as captured at the most recent clock edge. A change on an input shows exactly one cycle later, and never before that edge.
- R10: With `cfg_we` low, `cfg_sel` and `cfg_wdata` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_in | input | 4*NUM_SLOTS | Device pin levels, bit 4*slot+pin |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0..3 steering A..D, 4/5 trigger low/high, 6/7 unused |
| cfg_wdata | input | 8 | Register write data |
| irq_out | output | 16 | Legacy IRQ levels, bit n = IRQ n |
| trig_mode | output | 16 | Trigger-mode bits, bit n = IRQ n, 1 = level |

## Verification
The bench builds the router with its default of eight slots, which is twice the rotation period. Slots 4 to 7 therefore land on the same lines as slots 0 to 3, and several pins can be stacked onto one intermediate line. Slot 0 is included, so the wrap-around of the rotation (slot 0, INTA onto PIRQ D) is reached. A single pin is walked over all 32 inputs, and steering values of exactly 16, 0x80 and 0xFF probe the disconnect boundary. A long stretch of pseudo-random levels and steering writes is compared every clock against a behavioural model, which covers overlapping and disconnected targets in many combinations.

// File: rtl/intx_steer_pkg.sv
package intx_steer_pkg;

    localparam int unsigned PINS_PER_SLOT = 4;
    localparam int unsigned NUM_PIRQ      = 4;
    localparam int unsigned NUM_IRQ       = 16;
    localparam int unsigned ROUTE_W       = 8;
    localparam int unsigned TRIG_BYTES    = NUM_IRQ / 8;
    localparam int unsigned PIRQ_IDX_W    = $clog2(NUM_PIRQ);

    localparam logic [ROUTE_W-1:0] ROUTE_OFF = 8'h80;

    typedef enum logic [2:0] {
        SEL_ROUTE_A = 3'd0,
        SEL_ROUTE_B = 3'd1,
        SEL_ROUTE_C = 3'd2,
        SEL_ROUTE_D = 3'd3,
        SEL_TRIG_LO = 3'd4,
        SEL_TRIG_HI = 3'd5,
        SEL_RSVD_6  = 3'd6,
        SEL_RSVD_7  = 3'd7
    } cfg_sel_e;

    typedef logic [ROUTE_W-1:0]            route_t;
    typedef route_t [NUM_PIRQ-1:0]         route_tbl_t;
    typedef logic [NUM_PIRQ-1:0]           pirq_vec_t;
    typedef logic [NUM_IRQ-1:0]            irq_vec_t;

    typedef struct packed {
        logic         we;
        cfg_sel_e     sel;
        logic [7:0]   data;
    } cfg_wr_t;

    // Intermediate line fed by a given slot/pin pair: (pin + slot - 1) mod 4.
    function automatic logic [PIRQ_IDX_W-1:0] pirq_of(int unsigned slot, int unsigned pin);
        return PIRQ_IDX_W'((pin + slot + NUM_PIRQ - 1) % NUM_PIRQ);
    endfunction

    // True when a steering byte selects the given legacy IRQ number.
    function automatic logic route_hits(route_t r, int unsigned irq);
        return (r < route_t'(NUM_IRQ)) && (r == route_t'(irq));
    endfunction

endpackage

// File: rtl/intx_level_store.sv
module intx_level_store
    import intx_steer_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned NUM_PINS = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] level_in,
    output pirq_vec_t           pirq_level
);

    logic [NUM_PINS-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= level_in;
        end
    end

    // Per line, gather the mask of device pins rotated onto it.
    genvar gl, gs, gp;
    generate
        for (gl = 0; gl < NUM_PIRQ; gl++) begin : g_line
            logic [NUM_PINS-1:0] member;
            for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
                for (gp = 0; gp < PINS_PER_SLOT; gp++) begin : g_pin
                    assign member[gs*PINS_PER_SLOT+gp] =
                        (pirq_of(gs, gp) == PIRQ_IDX_W'(gl)) ? lvl_q[gs*PINS_PER_SLOT+gp] : 1'b0;
                end
            end
            assign pirq_level[gl] = |member;
        end
    endgenerate

endmodule

// File: rtl/intx_cfg_regs.sv
module intx_cfg_regs
    import intx_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_wr_t    wr,
    output route_tbl_t routes,
    output irq_vec_t   trig
);

    route_tbl_t route_q;
    irq_vec_t   trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= {NUM_PIRQ{ROUTE_OFF}};
            trig_q  <= '0;
        end else if (wr.we) begin
            case (wr.sel)
                SEL_ROUTE_A,
                SEL_ROUTE_B,
                SEL_ROUTE_C,
                SEL_ROUTE_D: route_q[wr.sel[PIRQ_IDX_W-1:0]] <= wr.data;
                SEL_TRIG_LO: trig_q[7:0]  <= wr.data;
                SEL_TRIG_HI: trig_q[15:8] <= wr.data;
                default:     ;
            endcase
        end
    end

    assign routes = route_q;
    assign trig   = trig_q;

endmodule

// File: rtl/intx_irq_steer.sv
module intx_irq_steer
    import intx_steer_pkg::*;
(
    input  pirq_vec_t  pirq_level,
    input  route_tbl_t routes,
    output irq_vec_t   irq
);

    genvar gn, gk;
    generate
        for (gn = 0; gn < NUM_IRQ; gn++) begin : g_irq
            pirq_vec_t hit;
            for (gk = 0; gk < NUM_PIRQ; gk++) begin : g_src
                assign hit[gk] = pirq_level[gk] & route_hits(routes[gk], gn);
            end
            assign irq[gn] = |hit;
        end
    endgenerate

endmodule

// File: rtl/intx_steer_router.sv
module intx_steer_router
    import intx_steer_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned NUM_PINS = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] level_in,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [7:0]          cfg_wdata,
    output logic [15:0]         irq_out,
    output logic [15:0]         trig_mode
);

    cfg_wr_t    wr;
    route_tbl_t routes;
    pirq_vec_t  pirq_level;
    irq_vec_t   irq_w;
    irq_vec_t   trig_w;

    assign wr.we   = cfg_we;
    assign wr.sel  = cfg_sel_e'(cfg_sel);
    assign wr.data = cfg_wdata;

    intx_level_store #(.NUM_SLOTS(NUM_SLOTS)) u_levels (
        .clk        (clk),
        .rst        (rst),
        .level_in   (level_in),
        .pirq_level (pirq_level)
    );

    intx_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .routes (routes),
        .trig   (trig_w)
    );

    intx_irq_steer u_steer (
        .pirq_level (pirq_level),
        .routes     (routes),
        .irq        (irq_w)
    );

    assign irq_out   = irq_w;
    assign trig_mode = trig_w;

endmodule

// File: rtl/intx_steer_checker.sv
module intx_steer_checker #(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned NUM_PINS = NUM_SLOTS * 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] level_in,
    input logic                cfg_we,
    input logic [2:0]          cfg_sel,
    input logic [7:0]          cfg_wdata,
    input logic [15:0]         irq_out,
    input logic [15:0]         trig_mode
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (irq_out == 16'h0 && trig_mode == 16'h0)); // R1

    AST_QUIET_PINS: assert property (@(posedge clk) disable iff (rst)
        (level_in == '0) |=> (irq_out == 16'h0)); // R3

    AST_FOUR_TARGETS: assert property (@(posedge clk) disable iff (rst)
        ($countones(irq_out) <= 4)); // R6

    AST_TRIG_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd4) |=> (trig_mode[7:0] == $past(cfg_wdata))); // R7

    AST_TRIG_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd5) |=> (trig_mode[15:8] == $past(cfg_wdata))); // R7

    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel[2:1] == 2'b11) |=> $stable(trig_mode)); // R8

    AST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(trig_mode)); // R10

endmodule

bind intx_steer_router intx_steer_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/intx_steer_router_bench.sv
module intx_steer_router_bench;

    localparam int NS = 8;
    localparam int NP = NS * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] level_in = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [15:0]   irq_out;
    logic [15:0]   trig_mode;

    int    tests = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    intx_steer_router #(.NUM_SLOTS(NS)) u_intx_steer_router (.*);

    always #10 clk = ~clk;

    // Behavioural reference state
    int          m_route [4];
    logic [15:0] m_trig;
    logic [NP-1:0] m_lvl;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int k = 0; k < 4; k++) m_route[k] = 128;
            m_trig = '0;
            m_lvl  = '0;
        end else begin
            m_lvl = level_in;
            if (cfg_we) begin
                if (cfg_sel < 4) m_route[cfg_sel] = int'(cfg_wdata);
                else if (cfg_sel == 4) m_trig[7:0] = cfg_wdata;
                else if (cfg_sel == 5) m_trig[15:8] = cfg_wdata;
            end
        end
    end

    function automatic logic [15:0] model_irq();
        logic [3:0]  line = '0;
        logic [15:0] e = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (m_lvl[s*4+p]) line[(p + s + 3) % 4] = 1'b1;
        for (int k = 0; k < 4; k++)
            if (line[k] && m_route[k] < 16) e[m_route[k]] = 1'b1;
        return e;
    endfunction

    // Per-clock comparison against the reference
    always @(negedge clk) begin
        if (cycles > 0) begin
            tests++;
            if (irq_out !== model_irq() || trig_mode !== m_trig) begin
                fails++;
                $display("FAIL %s model: irq %h/%h trig %h/%h (actual/expected)",
                         cur_req, irq_out, model_irq(), trig_mode, m_trig);
            end
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setlvl(logic [NP-1:0] v);
        @(negedge clk);
        level_in = v;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, all routes disabled
        cur_req = "R1";
        #1;
        chk("R1 irq", irq_out, 16'h0);
        chk("R1 trig", trig_mode, 16'h0);
        setlvl('1);
        chk("R1 disabled", irq_out, 16'h0);
        setlvl('0);

        // R4: program A->3, B->5, C->9, D->12
        cur_req = "R4";
        wr(3'd0, 8'd3); wr(3'd1, 8'd5); wr(3'd2, 8'd9); wr(3'd3, 8'd12);
        setlvl(32'h0000_0010);
        chk("R4 A->3", irq_out, 16'h0008);

        // R2: rotation incl. slot 0 wrap and slot 7
        cur_req = "R2";
        setlvl(32'h0000_0200);
        chk("R2 s2 INTB", irq_out, 16'h0200);
        setlvl(32'h0000_0001);
        chk("R2 s0 INTA", irq_out, 16'h1000);
        setlvl(32'h8000_0000);
        chk("R2 s7 INTD", irq_out, 16'h0020);
        for (int i = 0; i < NP; i++) setlvl(NP'(1) << i);

        // R3: two pins on PIRQ A
        cur_req = "R3";
        setlvl(32'h0010_0010);
        chk("R3 both", irq_out, 16'h0008);
        setlvl(32'h0010_0000);
        chk("R3 one left", irq_out, 16'h0008);
        setlvl('0);

        // R9: one-cycle latency
        cur_req = "R9";
        @(negedge clk);
        level_in = 32'h0000_0010;
        #1 chk("R9 before edge", irq_out, 16'h0000);
        @(negedge clk); #1;
        chk("R9 after edge", irq_out, 16'h0008);
        setlvl('0);

        // R5: disconnect boundary
        cur_req = "R5";
        wr(3'd1, 8'd16);
        setlvl(32'h8000_0000);
        chk("R5 16", irq_out, 16'h0000);
        wr(3'd1, 8'hFF);
        setlvl(32'h8000_0000);
        chk("R5 FF", irq_out, 16'h0000);
        wr(3'd1, 8'd15);
        setlvl(32'h8000_0000);
        chk("R5 15 connects", irq_out, 16'h8000);

        // R6: A and C onto IRQ 7
        cur_req = "R6";
        wr(3'd0, 8'd7); wr(3'd2, 8'd7);
        setlvl(32'h0000_0010);
        chk("R6 A only", irq_out, 16'h0080);
        setlvl(32'h0000_0200);
        chk("R6 C only", irq_out, 16'h0080);
        setlvl(32'h0000_0210);
        chk("R6 both", irq_out, 16'h0080);

        // R7: trigger-mode storage, no effect on irq_out
        cur_req = "R7";
        wr(3'd4, 8'hA5); wr(3'd5, 8'h3C);
        #1;
        chk("R7 trig", trig_mode, 16'h3CA5);
        chk("R7 irq untouched", irq_out, 16'h0080);

        // R8: unused selects
        cur_req = "R8";
        wr(3'd6, 8'hFF); wr(3'd7, 8'h00);
        #1;
        chk("R8 trig", trig_mode, 16'h3CA5);
        setlvl(32'h0000_0010);
        chk("R8 route A kept", irq_out, 16'h0080);

        // R10: no strobe, bus active
        cur_req = "R10";
        @(negedge clk);
        cfg_sel = 3'd0; cfg_wdata = 8'd1;
        @(negedge clk);
        cfg_sel = 3'd4; cfg_wdata = 8'h00;
        @(negedge clk); #1;
        chk("R10 route A", irq_out, 16'h0080);
        chk("R10 trig", trig_mode, 16'h3CA5);

        // Mixed pseudo-random traffic
        cur_req = "R4";
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            level_in  = $urandom;
            cfg_we    = ($urandom % 3) == 0;
            cfg_sel   = 3'($urandom);
            cfg_wdata = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule